// File: doc/BRIEF.md
# Lockable Identification Page Controller

This block owns one extra 256-byte page that lives beside a serial EEPROM's main array. It can be sealed for good, after which it can only be read. It sits behind a two-wire slave front end that has already decoded the bus into single-cycle events: Start, the device select byte (type nibble and read/write bit), each address byte, each written data byte, each request for a read byte, and Stop. The bus carries one address byte per event; the first is the high byte and the second is the low byte. The controller answers every written data byte with an acknowledge decision. It stores accepted bytes straight into the page and returns read bytes from a shared byte pointer. It also keeps a sticky lock flag, which is shown on an output.

The page is reached only through its own type nibble. A write transaction uses one bit of the high address byte to choose its meaning. When the bit is clear, the transaction is a page write. When it is set, the transaction is a lock request. A lock request takes effect only when its single qualifying data byte is acknowledged and a Stop follows before any other event. The ordinary reset returns the transaction logic to idle. Neither the lock flag nor the page contents are touched by it. A separate factory-restore input clears both the flag and the page.

Top module: `idpage_ctrl`

## Requirements
- R1: Only a select whose type nibble equals 4'b1011 engages the block. After a select with any other type, written data bytes get NoAck and change nothing, and read requests raise no `rd_vld`.
- R2: After a page-type write select and two address bytes whose high byte has bit 2 (the page/lock selector) clear, each data byte is acknowledged while unlocked. `ack_vld` is 1 and `ack_ok` is 1 in the cycle after `ev_wdata`. The byte is stored at the offset given by the low address byte. All other high-byte bits are ignored.
- R3: The byte pointer advances by one per stored or read byte, and wraps from offset 255 to offset 0.
- R4: A lock request has the selector bit set and a single data byte with bit 1 set. That byte is acknowledged, and `locked` rises one cycle after a Stop that arrives with no other event in between. A Start, select, address or read event in between cancels the request.
- R5: A lock request data byte with bit 1 clear gets NoAck and leaves `locked` at 0.
- R6: A second data byte in the same lock request gets NoAck and cancels the pending lock.
- R7: While `locked` is 1, page-write data bytes and lock-request data bytes get NoAck, and the page is not modified.
- R8: A page-type read select followed by `ev_rd` pulses returns `mem[pointer]` on `rd_data`, with `rd_vld` high, one cycle after each `ev_rd`. The pointer is the one left by the last address byte or transfer. Reads work whether the page is locked or not.
- R9: `locked` is sticky. `rst_n` clears neither the flag nor the page. A cycle of `factory_clr` clears the flag and sets every page byte to 0.
- R10: `ack_vld` pulses only in the cycle after `ev_wdata`, and `rd_vld` only in the cycle after an engaged `ev_rd`. Both are 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset of transaction state and pointer |
| factory_clr | input | 1 | Synchronous restore: clears the lock flag and the page |
| ev_start | input | 1 | Start or repeated Start seen |
| ev_stop | input | 1 | Stop seen |
| ev_sel | input | 1 | Select byte received |
| sel_type | input | 4 | Type nibble of the select byte |
| sel_rw | input | 1 | Read (1) or write (0) bit of the select byte |
| ev_addr | input | 1 | Address byte received on `bus_byte` |
| ev_wdata | input | 1 | Written data byte received on `bus_byte` |
| ev_rd | input | 1 | Master requests the next read byte |
| bus_byte | input | 8 | Address or data byte for the current event |
| ack_vld | output | 1 | Acknowledge decision valid |
| ack_ok | output | 1 | 1 = Ack, 0 = NoAck |
| rd_vld | output | 1 | Read byte valid |
| rd_data | output | 8 | Read byte |
| locked | output | 1 | Lock flag |

## Verification
The bench builds the block with its default parameters. These are a 256-byte page, a 4'b1011 type code, bit 2 of the high byte as the page/lock selector, and bit 1 as the lock payload bit. With these values, wrap from offset 255 can be reached within a few bytes, and the selector and payload positions match the requirement text. A behavioural model tracks the page, the pointer, the pending lock and the flag. It predicts every acknowledge, read byte and lock state. The scenarios cover:
- cancelled lock requests, each cancelled in a different way;
- a real lock followed by rejected writes;
- a plain reset that must leave the lock and the data alone;
- a factory restore.

// File: rtl/idp_pkg.sv
package idp_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR_HI,
    ST_ADDR_LO,
    ST_WRITE,
    ST_READ
  } idp_state_e;

  // A lock payload qualifies when its chosen bit is set; other bits are free.
  function automatic logic lock_payload_ok(input logic [7:0] b, input int unsigned pos);
    return b[pos];
  endfunction

endpackage

// File: rtl/idp_lock.sv
module idp_lock (
  input  logic clk,
  input  logic factory_clr,
  input  logic lock_take,
  output logic locked
);
  // Only the factory restore clears the flag; the normal reset does not reach it.
  always_ff @(posedge clk) begin
    if (factory_clr)    locked <= 1'b0;
    else if (lock_take) locked <= 1'b1;
  end
endmodule

// File: rtl/idp_store.sv
module idp_store #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 256,
  parameter int OFS_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [OFS_W-1:0]  ofs,
  input  logic [DATA_W-1:0] wdata,
  output logic              rd_vld,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (clr) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (wr_en) begin
      mem[ofs] <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_vld  <= 1'b0;
      rd_data <= '0;
    end else begin
      rd_vld <= rd_en;
      if (rd_en) rd_data <= mem[ofs];
    end
  end
endmodule

// File: rtl/idp_seq.sv
module idp_seq
  import idp_pkg::*;
#(
  parameter int              DATA_W    = 8,
  parameter int              TYPE_W    = 4,
  parameter int              OFS_W     = 8,
  parameter logic [TYPE_W-1:0] PAGE_TYPE = 4'b1011,
  parameter int              SEL_BIT   = 2,
  parameter int              LOCK_BIT  = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_start,
  input  logic              ev_stop,
  input  logic              ev_sel,
  input  logic [TYPE_W-1:0] sel_type,
  input  logic              sel_rw,
  input  logic              ev_addr,
  input  logic              ev_wdata,
  input  logic              ev_rd,
  input  logic [DATA_W-1:0] bus_byte,
  input  logic              locked,
  output logic              wr_en,
  output logic              rd_en,
  output logic [OFS_W-1:0]  ofs,
  output logic              ack_vld,
  output logic              ack_ok,
  output logic              lock_take,
  output logic              arm
);
  idp_state_e st;
  logic       lock_cmd;
  logic       first_q;
  logic       byte_ok;
  logic       any_ev;

  function automatic logic [OFS_W-1:0] step_ofs(input logic [OFS_W-1:0] o);
    return o + 1'b1;
  endfunction

  always_comb begin
    byte_ok = 1'b0;
    if (ev_wdata && st == ST_WRITE) begin
      if (!lock_cmd) byte_ok = !locked;
      else           byte_ok = first_q && !locked && lock_payload_ok(bus_byte, LOCK_BIT);
    end
  end

  assign wr_en     = byte_ok && !lock_cmd;
  assign rd_en     = ev_rd && st == ST_READ;
  assign lock_take = ev_stop && arm;
  assign any_ev    = ev_start | ev_stop | ev_sel | ev_addr | ev_wdata | ev_rd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      ofs      <= '0;
      lock_cmd <= 1'b0;
      first_q  <= 1'b0;
      arm      <= 1'b0;
      ack_vld  <= 1'b0;
      ack_ok   <= 1'b0;
    end else begin
      ack_vld <= ev_wdata;
      ack_ok  <= byte_ok;
      if (any_ev) arm <= byte_ok && lock_cmd;

      if (ev_start || ev_stop) begin
        st <= ST_IDLE;
      end else if (ev_sel) begin
        if (sel_type == PAGE_TYPE) st <= sel_rw ? ST_READ : ST_ADDR_HI;
        else                       st <= ST_IDLE;
      end else if (ev_addr) begin
        case (st)
          ST_ADDR_HI: begin
            lock_cmd <= bus_byte[SEL_BIT];
            st       <= ST_ADDR_LO;
          end
          ST_ADDR_LO: begin
            ofs     <= bus_byte[OFS_W-1:0];
            first_q <= 1'b1;
            st      <= ST_WRITE;
          end
          default: ;
        endcase
      end else if (ev_wdata && st == ST_WRITE) begin
        first_q <= 1'b0;
        if (wr_en) ofs <= step_ofs(ofs);
      end else if (rd_en) begin
        ofs <= step_ofs(ofs);
      end
    end
  end
endmodule

// File: rtl/idpage_ctrl.sv
module idpage_ctrl #(
  parameter int                PAGE_BYTES = 256,
  parameter int                DATA_W     = 8,
  parameter int                TYPE_W     = 4,
  parameter logic [TYPE_W-1:0] PAGE_TYPE  = 4'b1011,
  parameter int                SEL_BIT    = 2,
  parameter int                LOCK_BIT   = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              factory_clr,
  input  logic              ev_start,
  input  logic              ev_stop,
  input  logic              ev_sel,
  input  logic [TYPE_W-1:0] sel_type,
  input  logic              sel_rw,
  input  logic              ev_addr,
  input  logic              ev_wdata,
  input  logic              ev_rd,
  input  logic [DATA_W-1:0] bus_byte,
  output logic              ack_vld,
  output logic              ack_ok,
  output logic              rd_vld,
  output logic [DATA_W-1:0] rd_data,
  output logic              locked
);
  localparam int OFS_W = $clog2(PAGE_BYTES);

  logic             wr_en;
  logic             rd_en;
  logic [OFS_W-1:0] ofs;
  logic             lock_take;
  logic             arm;

  idp_seq #(
    .DATA_W(DATA_W), .TYPE_W(TYPE_W), .OFS_W(OFS_W),
    .PAGE_TYPE(PAGE_TYPE), .SEL_BIT(SEL_BIT), .LOCK_BIT(LOCK_BIT)
  ) u_seq (
    .clk(clk), .rst_n(rst_n),
    .ev_start(ev_start), .ev_stop(ev_stop), .ev_sel(ev_sel),
    .sel_type(sel_type), .sel_rw(sel_rw), .ev_addr(ev_addr),
    .ev_wdata(ev_wdata), .ev_rd(ev_rd), .bus_byte(bus_byte),
    .locked(locked), .wr_en(wr_en), .rd_en(rd_en), .ofs(ofs),
    .ack_vld(ack_vld), .ack_ok(ack_ok), .lock_take(lock_take), .arm(arm)
  );

  idp_store #(.DATA_W(DATA_W), .DEPTH(PAGE_BYTES), .OFS_W(OFS_W)) u_store (
    .clk(clk), .rst_n(rst_n), .clr(factory_clr),
    .wr_en(wr_en), .rd_en(rd_en), .ofs(ofs), .wdata(bus_byte),
    .rd_vld(rd_vld), .rd_data(rd_data)
  );

  idp_lock u_lock (
    .clk(clk), .factory_clr(factory_clr), .lock_take(lock_take), .locked(locked)
  );
endmodule

// File: rtl/idp_chk.sv
module idp_chk #(
  parameter int OFS_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             factory_clr,
  input logic             locked,
  input logic             wr_en,
  input logic             lock_take,
  input logic             ack_vld,
  input logic             ack_ok,
  input logic [OFS_W-1:0] ofs
);
  p_wr_only_unlocked_r7: assert property (@(posedge clk) disable iff (!rst_n || factory_clr)
    wr_en |-> !locked);

  p_wr_acked_r2: assert property (@(posedge clk) disable iff (!rst_n || factory_clr)
    wr_en |=> (ack_vld && ack_ok));

  p_ofs_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (ofs == $past(ofs) + 1'b1));

  p_lock_sticky_r9: assert property (@(posedge clk) disable iff (factory_clr)
    locked |=> locked);

  p_lock_cause_r4: assert property (@(posedge clk) disable iff (factory_clr)
    $rose(locked) |-> $past(lock_take));

  p_ack_framed_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ack_ok |-> ack_vld);
endmodule

bind idpage_ctrl idp_chk #(.OFS_W(OFS_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .factory_clr(factory_clr), .locked(locked),
  .wr_en(wr_en), .lock_take(lock_take), .ack_vld(ack_vld), .ack_ok(ack_ok),
  .ofs(ofs)
);

// File: tb/tb_idpage_ctrl.sv
module tb_idpage_ctrl;
  logic       clk = 1'b0;
  logic       rst_n, factory_clr;
  logic       ev_start, ev_stop, ev_sel, sel_rw, ev_addr, ev_wdata, ev_rd;
  logic [3:0] sel_type;
  logic [7:0] bus_byte;
  logic       ack_vld, ack_ok, rd_vld, locked;
  logic [7:0] rd_data;

  always #5 clk = ~clk;

  idpage_ctrl dut (
    .clk(clk), .rst_n(rst_n), .factory_clr(factory_clr),
    .ev_start(ev_start), .ev_stop(ev_stop), .ev_sel(ev_sel),
    .sel_type(sel_type), .sel_rw(sel_rw), .ev_addr(ev_addr),
    .ev_wdata(ev_wdata), .ev_rd(ev_rd), .bus_byte(bus_byte),
    .ack_vld(ack_vld), .ack_ok(ack_ok), .rd_vld(rd_vld), .rd_data(rd_data),
    .locked(locked)
  );

  // Behavioural reference model
  int unsigned m_mem [256];
  int unsigned m_ptr;
  int          m_st;      // 0 idle, 1 hi, 2 lo, 3 write, 4 read
  bit          m_lk, m_first, m_arm, m_lock;
  int          n_run = 0, n_fail = 0;
  bit          done = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick_and_lock_check();
    @(negedge clk);
    ev_start = 0; ev_stop = 0; ev_sel = 0; ev_addr = 0; ev_wdata = 0; ev_rd = 0;
  endtask

  task automatic do_start();
    ev_start = 1; tick_and_lock_check();
    m_st = 0; m_arm = 0;
  endtask

  task automatic do_stop();
    ev_stop = 1; tick_and_lock_check();
    if (m_arm) m_lock = 1;
    m_arm = 0; m_st = 0;
    @(negedge clk);
    chk("R4 lock flag after stop", locked, m_lock);
  endtask

  task automatic do_sel(input logic [3:0] t, input logic rw);
    sel_type = t; sel_rw = rw; ev_sel = 1; tick_and_lock_check();
    m_st = (t == 4'b1011) ? (rw ? 4 : 1) : 0; m_arm = 0;
  endtask

  task automatic do_addr(input logic [7:0] b);
    bus_byte = b; ev_addr = 1; tick_and_lock_check();
    if (m_st == 1) begin m_lk = b[2]; m_st = 2; end
    else if (m_st == 2) begin m_ptr = b; m_first = 1; m_st = 3; end
    m_arm = 0;
  endtask

  task automatic do_wdata(input string tag, input logic [7:0] b);
    bit exp;
    exp = 0;
    if (m_st == 3) exp = m_lk ? (m_first && !m_lock && b[1]) : !m_lock;
    bus_byte = b; ev_wdata = 1; tick_and_lock_check();
    chk({tag, " ack_vld"}, ack_vld, 1);
    chk({tag, " ack_ok"}, ack_ok, exp);
    if (m_st == 3 && !m_lk && exp) begin m_mem[m_ptr] = b; m_ptr = (m_ptr + 1) % 256; end
    if (m_st == 3) m_first = 0;
    m_arm = exp && m_lk && (m_st == 3);
    chk("R4 lock flag", locked, m_lock);
  endtask

  task automatic do_rd(input string tag);
    bit vexp; int unsigned dexp;
    vexp = (m_st == 4); dexp = m_mem[m_ptr];
    ev_rd = 1; tick_and_lock_check();
    chk({tag, " rd_vld"}, rd_vld, vexp);
    if (vexp) begin
      chk({tag, " rd_data"}, rd_data, dexp);
      m_ptr = (m_ptr + 1) % 256;
    end
    chk("R10 ack_vld idle on read", ack_vld, 0);
    m_arm = 0;
  endtask

  task automatic rand_read_setup(input logic [7:0] lo);
    do_start(); do_sel(4'b1011, 0); do_addr(8'h00); do_addr(lo);
    do_start(); do_sel(4'b1011, 1);
  endtask

  task automatic lock_req_begin();
    do_start(); do_sel(4'b1011, 0); do_addr(8'h04); do_addr(8'h00);
  endtask

  initial begin
    rst_n = 0; factory_clr = 1;
    ev_start = 0; ev_stop = 0; ev_sel = 0; ev_addr = 0; ev_wdata = 0; ev_rd = 0;
    sel_type = 0; sel_rw = 0; bus_byte = 0;
    for (int i = 0; i < 256; i++) m_mem[i] = 0;
    m_ptr = 0; m_st = 0; m_lk = 0; m_first = 0; m_arm = 0; m_lock = 0;
    repeat (3) @(negedge clk);
    factory_clr = 0; rst_n = 1;
    @(negedge clk);
    chk("R10 reset ack_vld", ack_vld, 0);
    chk("R10 reset rd_vld", rd_vld, 0);
    chk("R9 reset locked", locked, 0);

    // R2/R3: page write from offset FE with other high bits set, wraps to 00
    do_start(); do_sel(4'b1011, 0); do_addr(8'hFB); do_addr(8'hFE);
    do_wdata("R2 write FE", 8'h11);
    do_wdata("R2 write FF", 8'h22);
    do_wdata("R3 write wraps to 00", 8'h33);
    do_stop();

    // R8/R3: random read across the wrap
    rand_read_setup(8'hFE);
    do_rd("R8 read FE"); do_rd("R8 read FF"); do_rd("R3 read wrap 00");
    do_rd("R8 current-address read 01");
    do_stop();

    // R1: main-array type is ignored
    do_start(); do_sel(4'b1010, 0); do_addr(8'h00); do_addr(8'hFE);
    do_wdata("R1 foreign write", 8'hAA);
    do_stop();
    do_start(); do_sel(4'b1010, 1); do_rd("R1 foreign read"); do_stop();
    rand_read_setup(8'hFE); do_rd("R1 page unchanged FE"); do_stop();

    // R5: payload with bit 1 clear
    lock_req_begin(); do_wdata("R5 bad payload", 8'hFD); do_stop();
    // R6: two payload bytes
    lock_req_begin(); do_wdata("R6 first byte", 8'h02); do_wdata("R6 second byte", 8'h02); do_stop();
    // R4: restart between payload and stop cancels
    lock_req_begin(); do_wdata("R4 payload", 8'h02); do_start(); do_stop();
    // R4: proper lock (idle cycles between ack and stop are allowed)
    lock_req_begin(); do_wdata("R4 payload", 8'hFF); @(negedge clk); do_stop();
    chk("R4 locked set", locked, 1);

    // R7: writes and lock attempts rejected while locked
    do_start(); do_sel(4'b1011, 0); do_addr(8'h00); do_addr(8'h10);
    do_wdata("R7 locked write", 8'h5A); do_wdata("R7 locked write 2", 8'h5B); do_stop();
    lock_req_begin(); do_wdata("R7 relock", 8'h02); do_stop();
    rand_read_setup(8'h10); do_rd("R7 page unchanged 10"); do_stop();

    // R9: plain reset keeps lock and data
    rst_n = 0; @(negedge clk); rst_n = 1;
    m_st = 0; m_ptr = 0; m_arm = 0; m_first = 0;
    @(negedge clk);
    chk("R9 lock survives rst_n", locked, 1);
    rand_read_setup(8'hFF); do_rd("R9 data survives rst_n"); do_rd("R8 locked read 00"); do_stop();

    // R9: factory restore
    factory_clr = 1; @(negedge clk); factory_clr = 0;
    m_lock = 0; for (int i = 0; i < 256; i++) m_mem[i] = 0;
    @(negedge clk);
    chk("R9 factory clears lock", locked, 0);
    rand_read_setup(8'hFE); do_rd("R9 factory clears page"); do_stop();
    do_start(); do_sel(4'b1011, 0); do_addr(8'h00); do_addr(8'h20);
    do_wdata("R2 write after restore", 8'h77); do_stop();

    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule